// File: doc/BRIEF.md
# Microcontroller Bus Adapter

This block sits between the pins of an external microcontroller bus and a single internal access interface. A static style code tells it how to read a small set of shared control pins. Each pin can act as a read or write strobe, a read/write direction line, an enable, a data strobe, a byte-high or byte-low enable, a size bit or an address bit, depending on the style. Whatever the host protocol, the internal side sees the same things: a one-cycle read pulse, a one-cycle write pulse, the access address, two byte-lane enables and the write data.

All pins are brought into the system clock through a synchronizer. In multiplexed styles, the address travels on the shared address/data lines, and a dedicated latch-enable input captures it. In non-multiplexed styles, the address comes from separate address pins. During a read that targets this block, the adapter returns the internal read data on the shared lines. It enables the output drivers only for the active byte lanes. When no internal target is selected, the drivers stay off.

Top module: `mcu_bus_bridge`

## Requirements
- R1: After reset, `accRd`, `accWr`, `laneEn`, `accAddr`, `adOe` and `adOut` are all zero.
- R2: Each assertion of a read or write strobe produces exactly one single-cycle pulse on `accRd` or `accWr`, on the third rising clock edge after the pins change. In style 0 (8-bit multiplexed, RD on `pinCtlA`, WR on `pinCtlB`, program-fetch enable on `pinSelHi`, all active low), a low program-fetch enable counts as a read.
- R3: In direction-line styles, `pinCtlB` is R/W: high means read and low means write. An access happens only while the strobe on `pinCtlA` is active. In style 1 that strobe is E and is active high. In styles 5 and 6 it is DS, active low. In style 4, either LDS (`pinCtlA`) or UDS (`pinSelHi`) low counts as the strobe.
- R4: In multiplexed styles (0, 2, 3, and style 1 with `cfgMux`=1), `adIn` is captured while `pinAle` is high. The value is held after `pinAle` falls and becomes `accAddr`. Bit 0 of the captured value serves as A0.
- R5: In non-multiplexed styles, `accAddr` is `addrIn` with bit 0 taken from A0. A0 is `pinSelLo` in styles 1 and 5. In word-only styles 4 and 6, A0 is 0.
- R6: In 8-bit operation (style 0, or styles 1, 2 and 5 with `cfgWide`=0), `laneEn` is 2'b01. Bit 0 of `laneEn` is the low byte [7:0] and bit 1 is the high byte [15:8].
- R7: In styles 1 and 2 at 16 bits, the low lane is enabled when A0=0, and the high lane when the active-low byte-high enable on `pinSelHi` is 0.
- R8: In style 3, `pinCtlA` is RD, `pinCtlB` is the low-byte write strobe and `pinSelHi` is the high-byte write strobe. Either write strobe low starts a write, and each enables its own lane. A read enables both lanes.
- R9: In style 4, LDS low enables the low lane and UDS low enables the high lane. In style 6 (BHE on `pinSelHi`, BLE on `pinSelLo`), BLE low enables the low lane and BHE low enables the high lane.
- R10: In style 5 at 16 bits, when the size bit on `pinSelHi` is 1, only one lane is enabled: the low lane if A0=0, the high lane if A0=1. When the size bit is 0, both lanes are enabled.
- R11: On a write pulse, `wrData` holds the value that was on `adIn` when the write strobe became active.
- R12: While a read is active and `targetSel` is 1, `adOut` carries `rdData` and `adOe` equals the active lanes. Otherwise `adOe` is 0.
- R13: If the read and write strobes become active in the same cycle, only the write is taken: `accWr` pulses, `accRd` stays low and `adOe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgStyle | input | 3 | Bus style code 0..6 |
| cfgWide | input | 1 | 16-bit data in styles 1, 2, 5 |
| cfgMux | input | 1 | Multiplexed address in style 1 |
| pinCtlA | input | 1 | RD / E / DS / LDS |
| pinCtlB | input | 1 | WR / R/W / low-byte write |
| pinSelHi | input | 1 | Byte-high enable / fetch enable / high-byte write / UDS / size |
| pinSelLo | input | 1 | A0 / BLE |
| pinAle | input | 1 | Address latch enable, active high |
| addrIn | input | ADDR_W-1 | Non-multiplexed address bits [ADDR_W-1:1] |
| adIn | input | 16 | Shared address/data lines, input side |
| adOut | output | 16 | Shared address/data lines, output side |
| adOe | output | 2 | Per-lane output enable |
| targetSel | input | 1 | An internal target is selected |
| rdData | input | 16 | Internal read data |
| accRd | output | 1 | Read access pulse |
| accWr | output | 1 | Write access pulse |
| accAddr | output | ADDR_W | Access address |
| laneEn | output | 2 | Byte-lane enables of the last access |
| wrData | output | 16 | Write data of the last write |

## Verification
The read decode and the write decode can both fire in the same synchronized cycle in the strobe-pair styles. The bench provokes this in style 2 by pulling RD and WR low together while a target is selected. The result is judged at the ports: the write pulse count must rise by one, the read pulse count must not change, and the output enables must stay off. A second same-cycle case is a strobe that overlaps the tail of the address-latch window. The bench keeps these apart by design and checks that the captured address survives into the access.

// File: rtl/mcu_bus_pkg.sv
package mcu_bus_pkg;

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    STYLE_RDWR_FETCH = 3'd0,
    STYLE_RW_ENABLE  = 3'd1,
    STYLE_RDWR_BHE   = 3'd2,
    STYLE_SPLIT_WR   = 3'd3,
    STYLE_RW_LDS_UDS = 3'd4,
    STYLE_RW_DS_SIZE = 3'd5,
    STYLE_RW_DS_BLE  = 3'd6
  } busStyle_e;

  typedef struct packed {
    logic             rdPulse;
    logic             wrPulse;
    logic             driveRead;
    logic             aleOpen;
    logic             muxAddr;
    logic             a0;
    logic [LANES-1:0] lanes;
  } ctlStrobe_t;

endpackage

// File: rtl/mcu_bus_sync.sv
module mcu_bus_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= RST_VAL;
      else       stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/mcu_bus_ctrl.sv
module mcu_bus_ctrl
  import mcu_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgStyle,
  input  logic       cfgWide,
  input  logic       cfgMux,
  input  logic       pinCtlA,
  input  logic       pinCtlB,
  input  logic       pinSelHi,
  input  logic       pinSelLo,
  input  logic       pinAle,
  input  logic       targetSel,
  input  logic       latchA0,
  output ctlStrobe_t strobe
);

  logic [4:0] pinRaw, pinSync;
  logic       ctlA, ctlB, selHi, selLo, aleS;

  assign pinRaw = {pinAle, pinSelLo, pinSelHi, pinCtlB, pinCtlA};

  mcu_bus_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b01111)) u_pinSync (
    .clk (clk),
    .rstN(rstN),
    .d   (pinRaw),
    .q   (pinSync)
  );

  assign {aleS, selLo, selHi, ctlB, ctlA} = pinSync;

  busStyle_e        style;
  logic             muxMode, wideMode, rdAct, wrAct, a0, strobeOn;
  logic [LANES-1:0] lanes;

  assign style = busStyle_e'(cfgStyle);

  always_comb begin
    muxMode  = 1'b0;
    wideMode = 1'b1;
    rdAct    = 1'b0;
    wrAct    = 1'b0;
    a0       = 1'b0;
    strobeOn = 1'b0;
    lanes    = 2'b11;
    case (style)
      STYLE_RDWR_FETCH: begin
        muxMode  = 1'b1;
        wideMode = 1'b0;
        rdAct    = !ctlA || !selHi;
        wrAct    = !ctlB;
        a0       = latchA0;
      end
      STYLE_RW_ENABLE: begin
        muxMode  = cfgMux;
        wideMode = cfgWide;
        strobeOn = ctlA;
        rdAct    = strobeOn && ctlB;
        wrAct    = strobeOn && !ctlB;
        a0       = cfgMux ? latchA0 : selLo;
        lanes    = {!selHi, !a0};
      end
      STYLE_RDWR_BHE: begin
        muxMode  = 1'b1;
        wideMode = cfgWide;
        rdAct    = !ctlA;
        wrAct    = !ctlB;
        a0       = latchA0;
        lanes    = {!selHi, !a0};
      end
      STYLE_SPLIT_WR: begin
        muxMode  = 1'b1;
        rdAct    = !ctlA;
        wrAct    = !ctlB || !selHi;
        a0       = latchA0;
        lanes    = wrAct ? {!selHi, !ctlB} : 2'b11;
      end
      STYLE_RW_LDS_UDS: begin
        strobeOn = !ctlA || !selHi;
        rdAct    = strobeOn && ctlB;
        wrAct    = strobeOn && !ctlB;
        lanes    = {!selHi, !ctlA};
      end
      STYLE_RW_DS_SIZE: begin
        wideMode = cfgWide;
        strobeOn = !ctlA;
        rdAct    = strobeOn && ctlB;
        wrAct    = strobeOn && !ctlB;
        a0       = selLo;
        lanes    = selHi ? (a0 ? 2'b10 : 2'b01) : 2'b11;
      end
      STYLE_RW_DS_BLE: begin
        strobeOn = !ctlA;
        rdAct    = strobeOn && ctlB;
        wrAct    = strobeOn && !ctlB;
        lanes    = {!selHi, !selLo};
      end
      default: begin
        rdAct = 1'b0;
        wrAct = 1'b0;
      end
    endcase
    if (!wideMode) lanes = 2'b01;
  end

  // Previous activity; reset high so a level already active at release is not taken as an edge.
  logic rdPrev, wrPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev <= 1'b1;
      wrPrev <= 1'b1;
    end else begin
      rdPrev <= rdAct;
      wrPrev <= wrAct;
    end
  end

  always_comb begin
    strobe.wrPulse   = wrAct && !wrPrev;
    strobe.rdPulse   = rdAct && !rdPrev && !wrAct;
    strobe.driveRead = rdAct && !wrAct && targetSel;
    strobe.aleOpen   = muxMode && aleS;
    strobe.muxAddr   = muxMode;
    strobe.a0        = a0;
    strobe.lanes     = lanes;
  end

  // A write onset is never reported as a read edge (R13).
  p_write_masks_read_r13: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && rdAct) |-> !strobe.rdPulse);

  // A read pulse only follows a cycle without read activity (R2).
  p_read_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdPulse |=> !strobe.rdPulse);

endmodule

// File: rtl/mcu_bus_datapath.sv
module mcu_bus_datapath
  import mcu_bus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] adIn,
  input  logic [ADDR_W-1:1] addrIn,
  input  logic [DATA_W-1:0] rdData,
  output logic              latchA0,
  output logic              accRd,
  output logic              accWr,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  laneEn,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] adOut,
  output logic [LANES-1:0]  adOe
);

  localparam int BUS_W = DATA_W + ADDR_W - 1;

  logic [BUS_W-1:0]  busSync;
  logic [DATA_W-1:0] adInS;
  logic [ADDR_W-1:1] addrInS;
  logic [ADDR_W-1:0] addrLatch, addrNext;

  mcu_bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_busSync (
    .clk (clk),
    .rstN(rstN),
    .d   ({addrIn, adIn}),
    .q   (busSync)
  );

  assign {addrInS, adInS} = busSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrLatch <= '0;
    else if (strobe.aleOpen) addrLatch <= ADDR_W'(adInS);
  end

  assign latchA0  = addrLatch[0];
  assign addrNext = strobe.muxAddr ? addrLatch : {addrInS, strobe.a0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accRd   <= 1'b0;
      accWr   <= 1'b0;
      accAddr <= '0;
      laneEn  <= '0;
      wrData  <= '0;
      adOut   <= '0;
      adOe    <= '0;
    end else begin
      accRd <= strobe.rdPulse;
      accWr <= strobe.wrPulse;
      if (strobe.rdPulse || strobe.wrPulse) begin
        accAddr <= addrNext;
        laneEn  <= strobe.lanes;
      end
      if (strobe.wrPulse) wrData <= adInS;
      adOut <= strobe.driveRead ? rdData : '0;
      adOe  <= strobe.driveRead ? strobe.lanes : '0;
    end
  end

  p_rd_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    accRd |=> !accRd);

  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    accWr |=> !accWr);

  p_lane_present_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accRd || accWr) |-> (laneEn != '0));

  p_no_drive_on_write_r13: assert property (@(posedge clk) disable iff (!rstN)
    accWr |-> (adOe == '0));

  p_no_dual_access_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(accRd && accWr));

endmodule

// File: rtl/mcu_bus_bridge.sv
module mcu_bus_bridge
  import mcu_bus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgStyle,
  input  logic              cfgWide,
  input  logic              cfgMux,
  input  logic              pinCtlA,
  input  logic              pinCtlB,
  input  logic              pinSelHi,
  input  logic              pinSelLo,
  input  logic              pinAle,
  input  logic [ADDR_W-1:1] addrIn,
  input  logic [15:0]       adIn,
  output logic [15:0]       adOut,
  output logic [1:0]        adOe,
  input  logic              targetSel,
  input  logic [15:0]       rdData,
  output logic              accRd,
  output logic              accWr,
  output logic [ADDR_W-1:0] accAddr,
  output logic [1:0]        laneEn,
  output logic [15:0]       wrData
);

  ctlStrobe_t strobe;
  logic       latchA0;

  mcu_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgStyle (cfgStyle),
    .cfgWide  (cfgWide),
    .cfgMux   (cfgMux),
    .pinCtlA  (pinCtlA),
    .pinCtlB  (pinCtlB),
    .pinSelHi (pinSelHi),
    .pinSelLo (pinSelLo),
    .pinAle   (pinAle),
    .targetSel(targetSel),
    .latchA0  (latchA0),
    .strobe   (strobe)
  );

  mcu_bus_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .adIn   (adIn),
    .addrIn (addrIn),
    .rdData (rdData),
    .latchA0(latchA0),
    .accRd  (accRd),
    .accWr  (accWr),
    .accAddr(accAddr),
    .laneEn (laneEn),
    .wrData (wrData),
    .adOut  (adOut),
    .adOe   (adOe)
  );

endmodule

// File: tb/mcu_bus_bridge_bench.sv
`timescale 1ns/1ps
module mcu_bus_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgStyle = 3'd0;
  logic        cfgWide = 1'b0, cfgMux = 1'b0;
  logic        pinCtlA = 1'b1, pinCtlB = 1'b1, pinSelHi = 1'b1, pinSelLo = 1'b1, pinAle = 1'b0;
  logic [15:1] addrIn = '0;
  logic [15:0] adIn = '0, rdData = '0;
  logic        targetSel = 1'b0;
  logic [15:0] adOut, accAddr, wrData;
  logic [1:0]  adOe, laneEn;
  logic        accRd, accWr;

  int total = 0;
  int bad = 0;
  int rdCnt = 0;
  int wrCnt = 0;

  always #2.5 clk = ~clk;

  mcu_bus_bridge u_mcu_bus_bridge (
    .clk(clk), .rstN(rstN), .cfgStyle(cfgStyle), .cfgWide(cfgWide), .cfgMux(cfgMux),
    .pinCtlA(pinCtlA), .pinCtlB(pinCtlB), .pinSelHi(pinSelHi), .pinSelLo(pinSelLo),
    .pinAle(pinAle), .addrIn(addrIn), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .targetSel(targetSel), .rdData(rdData), .accRd(accRd), .accWr(accWr),
    .accAddr(accAddr), .laneEn(laneEn), .wrData(wrData)
  );

  always @(negedge clk) begin
    if (accRd) rdCnt <= rdCnt + 1;
    if (accWr) wrCnt <= wrCnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic startStyle(input logic [2:0] s, input logic wide, input logic mux);
    rstN = 1'b0;
    cfgStyle = s; cfgWide = wide; cfgMux = mux;
    pinCtlA = (s == 3'd1) ? 1'b0 : 1'b1;
    pinCtlB = 1'b1; pinSelHi = 1'b1; pinSelLo = 1'b1; pinAle = 1'b0;
    targetSel = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(3);
  endtask

  task automatic aleLatch(input logic [15:0] a);
    adIn = a; pinAle = 1'b1;
    cyc(3);
    pinAle = 1'b0;
    cyc(2);
  endtask

  task automatic testReset();
    startStyle(3'd0, 1'b0, 1'b0);
    chk(accRd == 0 && accWr == 0, "R1 pulses idle", {accRd, accWr}, 0);
    chk(adOe == 0 && adOut == 0, "R1 drivers off", adOe, 0);
    chk(laneEn == 0 && accAddr == 0, "R1 lanes/addr zero", accAddr, 0);
  endtask

  task automatic testStyle0();
    int r0, w0;
    startStyle(3'd0, 1'b0, 1'b0);
    r0 = rdCnt; w0 = wrCnt;
    aleLatch(16'h1235);
    rdData = 16'hA5C3; targetSel = 1'b1; adIn = 16'h0000;
    pinCtlA = 1'b0;
    cyc(6);
    chk(rdCnt == r0 + 1, "R2 one read pulse", rdCnt - r0, 1);
    chk(accAddr == 16'h1235, "R4 muxed address", accAddr, 16'h1235);
    chk(laneEn == 2'b01, "R6 narrow lane", laneEn, 1);
    chk(adOe == 2'b01 && adOut == 16'hA5C3, "R12 read drive", adOut, 16'hA5C3);
    pinCtlA = 1'b1;
    cyc(5);
    chk(adOe == 2'b00, "R12 drive released", adOe, 0);
    pinSelHi = 1'b0;
    cyc(6);
    chk(rdCnt == r0 + 2, "R2 fetch enable reads", rdCnt - r0, 2);
    pinSelHi = 1'b1;
    cyc(4);
    aleLatch(16'h2000);
    adIn = 16'h0077; pinCtlB = 1'b0;
    cyc(6);
    chk(wrCnt == w0 + 1, "R2 one write pulse", wrCnt - w0, 1);
    chk(wrData == 16'h0077, "R11 write data", wrData, 16'h0077);
    chk(accAddr == 16'h2000, "R4 address held past ALE", accAddr, 16'h2000);
    pinCtlB = 1'b1;
    cyc(4);
  endtask

  task automatic testStyle1();
    int r0, w0;
    startStyle(3'd1, 1'b1, 1'b0);
    r0 = rdCnt; w0 = wrCnt;
    addrIn = 15'h2000; pinSelLo = 1'b1; pinSelHi = 1'b0; pinCtlB = 1'b1;
    cyc(3);
    pinCtlA = 1'b1;
    cyc(6);
    chk(rdCnt == r0 + 1, "R3 E high with R/W high reads", rdCnt - r0, 1);
    chk(accAddr == 16'h4001, "R5 A0 from pin", accAddr, 16'h4001);
    chk(laneEn == 2'b10, "R7 odd address high lane", laneEn, 2);
    pinCtlA = 1'b0;
    cyc(3);
    pinSelLo = 1'b0; pinCtlB = 1'b0; adIn = 16'hBEEF;
    cyc(3);
    chk(wrCnt == w0, "R3 no access while E low", wrCnt - w0, 0);
    pinCtlA = 1'b1;
    cyc(6);
    chk(wrCnt == w0 + 1, "R3 E high with R/W low writes", wrCnt - w0, 1);
    chk(laneEn == 2'b11 && accAddr == 16'h4000, "R7 both lanes", laneEn, 3);
    pinCtlA = 1'b0;
    cyc(4);
  endtask

  task automatic testSplitWrite();
    int w0;
    startStyle(3'd3, 1'b1, 1'b0);
    w0 = wrCnt;
    aleLatch(16'h0100);
    pinSelHi = 1'b0;
    cyc(6);
    chk(wrCnt == w0 + 1 && laneEn == 2'b10, "R8 high write strobe only", laneEn, 2);
    pinSelHi = 1'b1;
    cyc(4);
    targetSel = 1'b1; pinCtlA = 1'b0;
    cyc(6);
    chk(laneEn == 2'b11 && adOe == 2'b11, "R8 read both lanes", laneEn, 3);
    pinCtlA = 1'b1;
    cyc(4);
  endtask

  task automatic testStrobeLanes();
    startStyle(3'd4, 1'b1, 1'b0);
    addrIn = 15'h0555; pinCtlB = 1'b1;
    cyc(3);
    pinCtlA = 1'b0;
    cyc(6);
    chk(laneEn == 2'b01, "R9 LDS low lane", laneEn, 1);
    chk(accAddr == 16'h0AAA, "R5 word-only bit0 zero", accAddr, 16'h0AAA);
    pinCtlA = 1'b1;
    cyc(4);
    startStyle(3'd6, 1'b1, 1'b0);
    pinCtlB = 1'b0; pinSelLo = 1'b0; pinSelHi = 1'b1;
    cyc(3);
    pinCtlA = 1'b0;
    cyc(6);
    chk(laneEn == 2'b01, "R9 BLE low lane", laneEn, 1);
    pinCtlA = 1'b1;
    cyc(4);
  endtask

  task automatic sizeAccess(input logic sz, input logic a, input logic [1:0] exp, input string tag);
    pinSelHi = sz; pinSelLo = a; pinCtlB = 1'b1;
    cyc(3);
    pinCtlA = 1'b0;
    cyc(6);
    chk(laneEn == exp, tag, laneEn, exp);
    pinCtlA = 1'b1;
    cyc(4);
  endtask

  task automatic testSize();
    startStyle(3'd5, 1'b1, 1'b0);
    sizeAccess(1'b1, 1'b1, 2'b10, "R10 byte at odd");
    sizeAccess(1'b1, 1'b0, 2'b01, "R10 byte at even");
    sizeAccess(1'b0, 1'b1, 2'b11, "R10 word");
  endtask

  task automatic testConflict();
    int r0, w0;
    startStyle(3'd2, 1'b0, 1'b0);
    aleLatch(16'h0300);
    pinSelHi = 1'b0; targetSel = 1'b0; pinCtlA = 1'b0;
    cyc(6);
    chk(laneEn == 2'b01, "R6 narrow ignores BHE", laneEn, 1);
    chk(adOe == 2'b00, "R12 unselected no drive", adOe, 0);
    pinCtlA = 1'b1;
    cyc(4);
    r0 = rdCnt; w0 = wrCnt;
    targetSel = 1'b1; pinCtlA = 1'b0; pinCtlB = 1'b0;
    cyc(6);
    chk(wrCnt == w0 + 1, "R13 write taken", wrCnt - w0, 1);
    chk(rdCnt == r0, "R13 read dropped", rdCnt - r0, 0);
    chk(adOe == 2'b00, "R13 no drive", adOe, 0);
    pinCtlA = 1'b1; pinCtlB = 1'b1;
    cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testStyle0();
    testStyle1();
    testSplitWrite();
    testStrobeLanes();
    testSize();
    testConflict();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule